// File: doc/BRIEF.md
# Scan and Conversion Timing Generator

This block paces a multichannel acquisition. Two programmable timers drive it. The scan timer opens each scan. The conversion timer spaces the channel conversions inside a scan. On every conversion the block emits a one-cycle strobe, together with the channel number and range code taken from a channel list. The list is loaded beforehand through a simple write port.

A start pulse launches acquisition, and the first scan begins at once. Acquisition ends in one of two ways: the programmed total number of samples has been strobed, which also produces a done pulse, or a stop pulse arrives. The timer settings, list length and sample limit are captured when acquisition starts.

The block is used in front of a converter and a sample buffer, and it contains neither of them.

Top module: `scan_timing_gen`

## Requirements
- R1: A timer setting is 20 bits: prescale in bits 19:16 and divider in bits 15:0. The conversion period is divider × CONV_BASE_CYC × (prescale+1) clock cycles. The scan period is divider × SCAN_BASE_CYC × (prescale+1) clock cycles. With a 100 MHz clock the defaults give base ticks of 50 ns and 100 ns.
- R2: A divider of 0 gives the same period as a divider of 1.
- R3: A start pulse sampled while idle produces the first strobe, for list entry 0, in the following cycle, and busy_o goes high in that same cycle.
- R4: Within a scan, exactly one strobe is issued per list entry, in list order, spaced by the conversion period. Each list entry is 8 bits. On each strobe, chan_o carries entry bits 5:0 and range_o carries entry bits 7:6.
- R5: A new scan starts at entry 0 one scan period after the previous scan started. A scan expiry takes priority over a conversion in the same cycle.
- R6: The list length ranges from 1 to 512 entries. A length of 0 acts as 1, and a length above 512 acts as 512. Entries are written with list_we_i at list_addr_i.
- R7: With a nonzero sample limit N, the Nth strobe is the last one. done_o is high for exactly that one cycle, and busy_o is low from that cycle onwards.
- R8: A sample limit of 0 keeps acquisition running until a stop pulse.
- R9: After a stop pulse is sampled, no strobe is issued from the next cycle on, busy_o is low, and done_o does not pulse.
- R10: A start pulse while busy is ignored, and the timing of the strobes that follow is unchanged.
- R11: After reset, strobe_o, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| conv_cfg_i | input | 20 | Conversion timer setting |
| scan_cfg_i | input | 20 | Scan timer setting |
| list_len_i | input | 10 | Entries per scan |
| sample_limit_i | input | 24 | Total strobes; 0 means unlimited |
| list_we_i | input | 1 | List write enable |
| list_addr_i | input | 9 | List write address |
| list_data_i | input | 8 | List entry: range in bits 7:6, channel in bits 5:0 |
| strobe_o | output | 1 | Conversion strobe |
| chan_o | output | 6 | Channel for the current strobe |
| range_o | output | 2 | Range code for the current strobe |
| busy_o | output | 1 | Acquisition running |
| done_o | output | 1 | Sample limit reached |

## Verification
A miscounting prescale or divider counter moves the strobes off their expected cycles. The error shows at the second strobe of a scan or at the second scan, so the bench compares the exact cycle of every strobe against a time computed from the settings. A wrong list index shows as a wrong channel or range on the very strobe that uses it. A wrong sample counter shows as a done pulse or a loss of busy on the wrong strobe, or as extra strobes after the limit. These appear within one scan period.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int PRE_W = 4;
  localparam int DIV_W = 16;
  localparam int TCFG_W = PRE_W + DIV_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } tcfg_t;
endpackage

// File: rtl/tg_tick_timer.sv
module tg_tick_timer
  import tg_pkg::*;
#(
  parameter int BASE_CYC = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  clear_i,
  input  tcfg_t cfg_i,
  output logic  expire_o
);
  localparam int BW = (BASE_CYC > 1) ? $clog2(BASE_CYC) : 1;

  logic [BW-1:0]    base_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic base_t, pre_t, div_t;

  // divider 0 behaves as 1
  assign div_last = (cfg_i.div == '0) ? '0 : cfg_i.div - 1'b1;
  assign base_t   = (base_cnt == BW'(BASE_CYC - 1));
  assign pre_t    = (pre_cnt == cfg_i.pre);
  assign div_t    = (div_cnt == div_last);
  assign expire_o = run_i & ~clear_i & base_t & pre_t & div_t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt <= '0;
      pre_cnt  <= '0;
      div_cnt  <= '0;
    end else if (clear_i || !run_i) begin
      base_cnt <= '0;
      pre_cnt  <= '0;
      div_cnt  <= '0;
    end else if (base_t) begin
      base_cnt <= '0;
      if (pre_t) begin
        pre_cnt <= '0;
        div_cnt <= div_t ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin
      base_cnt <= base_cnt + 1'b1;
    end
  end

  a_r2_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (div_cnt <= div_last));
  a_r1_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pre_cnt <= cfg_i.pre));
endmodule

// File: rtl/tg_chan_list.sv
module tg_chan_list #(
  parameter int DEPTH   = 512,
  parameter int ENTRY_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import tg_pkg::*;
#(
  parameter int CONV_BASE_CYC = 5,
  parameter int SCAN_BASE_CYC = 10,
  parameter int LIST_DEPTH    = 512,
  parameter int CHAN_W        = 6,
  parameter int RANGE_W       = 2,
  parameter int COUNT_W       = 24,
  localparam int ENTRY_W = CHAN_W + RANGE_W,
  localparam int IDX_W   = $clog2(LIST_DEPTH),
  localparam int LEN_W   = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [TCFG_W-1:0]  conv_cfg_i,
  input  logic [TCFG_W-1:0]  scan_cfg_i,
  input  logic [LEN_W-1:0]   list_len_i,
  input  logic [COUNT_W-1:0] sample_limit_i,
  input  logic               list_we_i,
  input  logic [IDX_W-1:0]   list_addr_i,
  input  logic [ENTRY_W-1:0] list_data_i,
  output logic               strobe_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int NT = 2;  // 0: conversion timer, 1: scan timer

  logic               busy_q, strobe_q, done_q;
  logic [LEN_W-1:0]   idx_q, len_q, len_in;
  logic [COUNT_W-1:0] cnt_q, limit_q, lim_sel, cnt_sel, cnt_nxt;
  tcfg_t              tcfg_q [NT];
  logic [NT-1:0]      t_clr, t_exp;
  logic [CHAN_W-1:0]  chan_q;
  logic [RANGE_W-1:0] range_q;
  logic [IDX_W-1:0]   rd_addr;
  logic [ENTRY_W-1:0] rd_entry;
  logic start_go, scan_go, conv_go, issue, last;

  generate
    for (genvar g = 0; g < NT; g++) begin : g_tmr
      tg_tick_timer #(.BASE_CYC(g == 0 ? CONV_BASE_CYC : SCAN_BASE_CYC)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (busy_q),
        .clear_i (t_clr[g]),
        .cfg_i   (tcfg_q[g]),
        .expire_o(t_exp[g])
      );
    end
  endgenerate

  tg_chan_list #(.DEPTH(LIST_DEPTH), .ENTRY_W(ENTRY_W)) u_list (
    .clk_i  (clk_i),
    .we_i   (list_we_i),
    .waddr_i(list_addr_i),
    .wdata_i(list_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_entry)
  );

  always_comb begin
    if (list_len_i == '0)                   len_in = LEN_W'(1);
    else if (list_len_i > LEN_W'(LIST_DEPTH)) len_in = LEN_W'(LIST_DEPTH);
    else                                    len_in = list_len_i;
  end

  assign start_go = start_i & ~busy_q & ~stop_i;
  assign scan_go  = busy_q & ~stop_i & t_exp[1];
  assign conv_go  = busy_q & ~stop_i & ~t_exp[1] & t_exp[0] & (idx_q < len_q);
  assign issue    = start_go | scan_go | conv_go;
  assign t_clr    = {start_go, start_go | scan_go};
  assign rd_addr  = (start_go | scan_go) ? '0 : idx_q[IDX_W-1:0];
  assign lim_sel  = start_go ? sample_limit_i : limit_q;
  assign cnt_sel  = start_go ? '0 : cnt_q;
  assign cnt_nxt  = cnt_sel + 1'b1;
  assign last     = issue && (lim_sel != '0) && (cnt_nxt == lim_sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      strobe_q  <= 1'b0;
      done_q    <= 1'b0;
      idx_q     <= '0;
      len_q     <= LEN_W'(1);
      cnt_q     <= '0;
      limit_q   <= '0;
      tcfg_q[0] <= '0;
      tcfg_q[1] <= '0;
      chan_q    <= '0;
      range_q   <= '0;
    end else begin
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      if (stop_i) begin
        busy_q <= 1'b0;
      end else if (issue) begin
        strobe_q <= 1'b1;
        chan_q   <= rd_entry[CHAN_W-1:0];
        range_q  <= rd_entry[ENTRY_W-1:CHAN_W];
        cnt_q    <= cnt_nxt;
        idx_q    <= (start_go | scan_go) ? LEN_W'(1) : idx_q + 1'b1;
        if (start_go) begin
          busy_q    <= 1'b1;
          len_q     <= len_in;
          limit_q   <= sample_limit_i;
          tcfg_q[0] <= tcfg_t'(conv_cfg_i);
          tcfg_q[1] <= tcfg_t'(scan_cfg_i);
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign strobe_o = strobe_q;
  assign chan_o   = chan_q;
  assign range_o  = range_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  a_r3_first_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> strobe_o);
  a_r7_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (strobe_o && !busy_o));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!strobe_o && !busy_o && !done_o));
  a_r6_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_q <= len_q));
  a_r10_start_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !stop_i && !t_exp[1] && !t_exp[0]) |=> !strobe_o);
endmodule

// File: tb/scan_timing_gen_tb.sv
module scan_timing_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, we = 1'b0;
  logic [19:0] conv_cfg = '0, scan_cfg = '0;
  logic [9:0]  len = 10'd1;
  logic [23:0] limit = '0;
  logic [8:0]  waddr = '0;
  logic [7:0]  wdata = '0;
  logic strobe, busy, done;
  logic [5:0] chan;
  logic [1:0] rng;

  int errors = 0, checks = 0;
  int cyc = 0, t0 = 0;
  int n_ev = 0, n_done = 0, done_cyc = 0;
  int ev_cyc [64];
  logic [5:0] ev_ch [64];
  logic [1:0] ev_rg [64];

  always #5 clk = ~clk;

  scan_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .conv_cfg_i(conv_cfg), .scan_cfg_i(scan_cfg), .list_len_i(len),
    .sample_limit_i(limit), .list_we_i(we), .list_addr_i(waddr),
    .list_data_i(wdata), .strobe_o(strobe), .chan_o(chan), .range_o(rng),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (strobe && n_ev < 64) begin
      ev_cyc[n_ev] = cyc;
      ev_ch[n_ev]  = chan;
      ev_rg[n_ev]  = rng;
      n_ev++;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int r, input int c);
    @(negedge clk);
    we = 1'b1; waddr = 9'(a); wdata = {2'(r), 6'(c)};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic go(input int cpre, input int cdiv, input int spre, input int sdiv,
                    input int l, input int lim);
    @(negedge clk);
    conv_cfg = {4'(cpre), 16'(cdiv)};
    scan_cfg = {4'(spre), 16'(sdiv)};
    len = 10'(l); limit = 24'(lim);
    n_ev = 0; n_done = 0;
    start = 1'b1;
    @(posedge clk);
    #1 t0 = cyc;
    start = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && busy; i++) @(negedge clk);
    repeat (100) @(negedge clk);
  endtask

  task automatic ev(input int k, input int dt, input int c, input int r, input string req);
    chk(n_ev > k, req, n_ev, k + 1);
    if (n_ev > k) begin
      chk(ev_cyc[k] == t0 + dt, req, ev_cyc[k] - t0, dt);
      chk(ev_ch[k] == 6'(c), req, ev_ch[k], c);
      chk(ev_rg[k] == 2'(r), req, ev_rg[k], r);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!strobe && !busy && !done, "R11", {strobe, busy, done}, 0);
  endtask

  // R1 R4 R5 R7: conv 10 cycles, scan 40 cycles, 3 entries, 6 samples
  task automatic t_basic;
    wr(0, 2, 5); wr(1, 1, 33); wr(2, 3, 63);
    go(0, 2, 0, 4, 3, 6);
    @(negedge clk);
    chk(busy, "R3", busy, 1);
    wait_idle(500);
    ev(0, 0, 5, 2, "R3");
    ev(1, 10, 33, 1, "R4");
    ev(2, 20, 63, 3, "R4");
    ev(3, 40, 5, 2, "R5");
    ev(4, 50, 33, 1, "R1");
    ev(5, 60, 63, 3, "R1");
    chk(n_ev == 6, "R7", n_ev, 6);
    chk(n_done == 1 && done_cyc == t0 + 60, "R7", done_cyc - t0, 60);
    chk(!busy, "R7", busy, 0);
  endtask

  // R1 prescale: conv 5*3*1=15, scan 10*2*3=60
  task automatic t_prescale;
    go(2, 1, 1, 3, 2, 4);
    wait_idle(500);
    ev(0, 0, 5, 2, "R1");
    ev(1, 15, 33, 1, "R1");
    ev(2, 60, 5, 2, "R1");
    ev(3, 75, 33, 1, "R1");
    chk(n_ev == 4, "R7", n_ev, 4);
  endtask

  // R2: dividers 0 act as 1 -> conv 5, scan 10
  task automatic t_div0;
    go(0, 0, 0, 0, 2, 4);
    wait_idle(500);
    ev(1, 5, 33, 1, "R2");
    ev(2, 10, 5, 2, "R2");
    ev(3, 15, 33, 1, "R2");
  endtask

  // R8 R9: unlimited run, then stop
  task automatic t_stop;
    go(0, 1, 0, 2, 1, 0);
    while (cyc < t0 + 50) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(n_ev == 3, "R8", n_ev, 3);
    repeat (80) @(negedge clk);
    chk(n_ev == 3, "R9", n_ev, 3);
    chk(!busy, "R9", busy, 0);
    chk(n_done == 0, "R9", n_done, 0);
  endtask

  // R10: start while busy ignored
  task automatic t_restart;
    go(0, 1, 0, 3, 1, 3);
    while (cyc < t0 + 12) @(negedge clk);
    conv_cfg = {4'd0, 16'd1}; scan_cfg = {4'd0, 16'd1};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle(500);
    ev(1, 30, 5, 2, "R10");
    ev(2, 60, 5, 2, "R10");
    chk(n_ev == 3, "R10", n_ev, 3);
  endtask

  // R6: length 0 acts as 1
  task automatic t_len0;
    go(0, 1, 0, 2, 0, 2);
    wait_idle(500);
    ev(0, 0, 5, 2, "R6");
    ev(1, 20, 5, 2, "R6");
    chk(n_ev == 2, "R6", n_ev, 2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_prescale();
    t_div0();
    t_stop();
    t_restart();
    t_len0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule